// File: doc/BRIEF.md
# Performance counter register access and read-index decoder

This block sits in front of two banks of event counters: a general bank and a fixed bank. It lets software-style requests write and read them. Each general counter can be written through two aliases. The narrow alias takes the low 32 bits of the write data and sign-extends them up to the counter width. The wide alias stores the whole value, but only when the value fits the counter. Wider values are refused with a fault. A third write code loads fixed counters with the same fit rule. Because both general aliases reach the same storage, a value written through one is what the other sees. Counting and interrupts live elsewhere; this block holds the counter values and arbitrates access to them.

Reads arrive as a packed 32-bit index word, which carries three fields:
- Bit 30 chooses the fixed group (1) or the general group (0).
- Bits 7:0 give the counter number within that group.
- Bit 31 asks for a fast read, which returns only the low 32 bits, zero-extended.

Bits 29:8 must be zero. An index that breaks any rule returns a fault flag and zero data, and no counter is touched. The read request is valid/ready, and a single response register holds the result. The result stays on the outputs until the consumer takes it. The request side is ready whenever that register is empty or being drained in the same cycle. The write port accepts every beat: `wr_ready` is held high. Its fault pulse `wr_fault` appears one cycle after the write is accepted.

Top module: `pmc_access`

## Requirements
- R1: A write with alias code 0 (narrow) stores data bits 31:0, with bit 31 copied into counter bits 47:32. Data bits 63:32 are ignored.
- R2: A write with alias code 1 (wide) whose data has bits 63:48 all zero stores the data unchanged in the general counter, with no fault.
- R3: A wide write (code 1) or a fixed write (code 2) with any of data bits 63:48 set raises `wr_fault` in the following cycle, and the addressed counter keeps its old value.
- R4: Codes 0 and 1 address the same general storage: a read returns the value of whichever alias wrote that counter last.
- R5: Read index bit 30 = 1 selects the fixed group, and bit 30 = 0 the general group. Index bits 7:0 give the counter number. Write code 2 writes fixed counter `wr_num`.
- R6: Read index bit 31 = 1 returns counter bits 31:0 in data bits 31:0, with data bits 63:32 zero.
- R7: A read index naming a counter that does not exist returns `rd_rsp_fault` = 1 and data zero. Nonexistent means number 4 or more in the general group, or 3 or more in the fixed group.
- R8: A read index with any of bits 29:8 set returns `rd_rsp_fault` = 1 and data zero.
- R9: A normal read (bit 31 = 0) returns the 48-bit counter value with data bits 63:48 zero.
- R10: While `rd_rsp_valid` is high and `rd_rsp_ready` is low, the response and its data and fault stay unchanged and `rd_req_ready` is low.
- R11: A write with code 3, or with `wr_num` outside the addressed group, raises `wr_fault` and changes no counter.
- R12: After reset all counters read zero, `rd_rsp_valid` and `wr_fault` are low, and `rd_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_alias | input | 2 | 0 narrow general, 1 wide general, 2 fixed, 3 reserved |
| wr_num | input | 8 | Counter number for the write |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | One-cycle pulse after a refused write |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_index | input | 32 | Packed read index word |
| rd_rsp_valid | output | 1 | Read response present |
| rd_rsp_ready | input | 1 | Consumer takes the response |
| rd_rsp_data | output | 64 | Read data |
| rd_rsp_fault | output | 1 | Read index was illegal |

## Verification
The assertions assume that a write and a read do not target the same counter in the same cycle, because a read then sees the value from before the write. They also assume that `rd_rsp_ready` is driven to a known level every cycle. The stimulus issues each write and each read in separate cycles. It drives every handshake input at the falling edge. It mixes random data shaped to fit, to overflow or to carry sign patterns with random index words. Some of those index words set reserved bits or name missing counters.

// File: rtl/pmc_access_pkg.sv
package pmc_access_pkg;

  typedef enum logic [1:0] {
    WR_NARROW = 2'd0,
    WR_WIDE   = 2'd1,
    WR_FIXED  = 2'd2,
    WR_RSVD   = 2'd3
  } wr_alias_e;

  typedef struct packed {
    logic fast;
    logic fixed_grp;
    logic fault;
  } rd_mode_t;

endpackage

// File: rtl/pmc_ctr_bank.sv
module pmc_ctr_bank #(
  parameter int W     = 48,
  parameter int N     = 4,
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NUM_W-1:0] wnum,
  input  logic [W-1:0]     wval,
  input  logic [NUM_W-1:0] rnum,
  output logic [W-1:0]     rval
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < N; i++)
        if (wnum == NUM_W'(i)) mem[i] <= wval;
    end
  end

  always_comb begin
    rval = '0;
    for (int i = 0; i < N; i++)
      if (rnum == NUM_W'(i)) rval = mem[i];
  end

  for (genvar g = 0; g < N; g++) begin : g_hold
    // a counter changes only when it is the target of an enabled write
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wnum == NUM_W'(g)) |=> $stable(mem[g]));
  end

endmodule

// File: rtl/pmc_wr_path.sv
module pmc_wr_path
  import pmc_access_pkg::*;
#(
  parameter int CW    = 48,
  parameter int FW    = 48,
  parameter int NG    = 4,
  parameter int NF    = 3,
  parameter int NUM_W = 8
) (
  input  logic             wr_valid,
  input  logic [1:0]       wr_alias,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [63:0]      wr_data,
  output logic             g_we,
  output logic             f_we,
  output logic [CW-1:0]    g_val,
  output logic [FW-1:0]    f_val,
  output logic             fault_now
);

  wr_alias_e kind;
  logic      g_hi_bad, f_hi_bad, num_bad, refuse;

  assign kind = wr_alias_e'(wr_alias);

  function automatic logic [CW-1:0] sext32(input logic [63:0] d);
    logic [CW-1:0] v;
    for (int i = 0; i < CW; i++) v[i] = (i < 32) ? d[i] : d[31];
    return v;
  endfunction

  assign g_hi_bad = |(wr_data >> CW);
  assign f_hi_bad = |(wr_data >> FW);

  always_comb begin
    num_bad = 1'b0;
    refuse  = 1'b0;
    g_val   = sext32(wr_data);
    f_val   = wr_data[FW-1:0];
    unique case (kind)
      WR_NARROW: num_bad = (wr_num >= NUM_W'(NG));
      WR_WIDE: begin
        num_bad = (wr_num >= NUM_W'(NG));
        refuse  = g_hi_bad;
        g_val   = wr_data[CW-1:0];
      end
      WR_FIXED: begin
        num_bad = (wr_num >= NUM_W'(NF));
        refuse  = f_hi_bad;
      end
      default: refuse = 1'b1;
    endcase
  end

  assign fault_now = wr_valid && (refuse || num_bad);
  assign g_we = wr_valid && !fault_now && (kind == WR_NARROW || kind == WR_WIDE);
  assign f_we = wr_valid && !fault_now && (kind == WR_FIXED);

endmodule

// File: rtl/pmc_rd_decode.sv
module pmc_rd_decode
  import pmc_access_pkg::*;
#(
  parameter int NG    = 4,
  parameter int NF    = 3,
  parameter int NUM_W = 8
) (
  input  logic [31:0]      idx,
  output logic [NUM_W-1:0] num,
  output rd_mode_t         mode
);

  localparam int HI_W = 30 - NUM_W;

  logic [HI_W-1:0] hi;
  logic            missing;

  assign hi  = idx[29:NUM_W];
  assign num = idx[NUM_W-1:0];

  always_comb begin
    if (idx[30]) missing = (num >= NUM_W'(NF));
    else         missing = (num >= NUM_W'(NG));
  end

  assign mode.fast      = idx[31];
  assign mode.fixed_grp = idx[30];
  assign mode.fault     = missing || (|hi);

endmodule

// File: rtl/pmc_access.sv
module pmc_access
  import pmc_access_pkg::*;
#(
  parameter int CW    = 48,
  parameter int FW    = 48,
  parameter int NG    = 4,
  parameter int NF    = 3,
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_alias,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [63:0]      wr_data,
  output logic             wr_fault,
  input  logic             rd_req_valid,
  output logic             rd_req_ready,
  input  logic [31:0]      rd_index,
  output logic             rd_rsp_valid,
  input  logic             rd_rsp_ready,
  output logic [63:0]      rd_rsp_data,
  output logic             rd_rsp_fault
);

  logic             g_we, f_we, fault_now;
  logic [CW-1:0]    g_wval, g_rval;
  logic [FW-1:0]    f_wval, f_rval;
  logic [NUM_W-1:0] rnum;
  rd_mode_t         mode, mode_q;
  logic [63:0]      sel_data;
  logic             accept;

  assign wr_ready = 1'b1;

  pmc_wr_path #(.CW(CW), .FW(FW), .NG(NG), .NF(NF), .NUM_W(NUM_W)) u_wr (
    .wr_valid (wr_valid),
    .wr_alias (wr_alias),
    .wr_num   (wr_num),
    .wr_data  (wr_data),
    .g_we     (g_we),
    .f_we     (f_we),
    .g_val    (g_wval),
    .f_val    (f_wval),
    .fault_now(fault_now)
  );

  pmc_ctr_bank #(.W(CW), .N(NG), .NUM_W(NUM_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .we(g_we), .wnum(wr_num), .wval(g_wval),
    .rnum(rnum), .rval(g_rval)
  );

  pmc_ctr_bank #(.W(FW), .N(NF), .NUM_W(NUM_W)) u_fix (
    .clk(clk), .rst_n(rst_n), .we(f_we), .wnum(wr_num), .wval(f_wval),
    .rnum(rnum), .rval(f_rval)
  );

  pmc_rd_decode #(.NG(NG), .NF(NF), .NUM_W(NUM_W)) u_dec (
    .idx (rd_index),
    .num (rnum),
    .mode(mode)
  );

  always_comb begin
    sel_data = '0;
    if (mode.fixed_grp) sel_data[FW-1:0] = f_rval;
    else                sel_data[CW-1:0] = g_rval;
    if (mode.fast) sel_data[63:32] = '0;
    if (mode.fault) sel_data = '0;
  end

  assign rd_req_ready = !rd_rsp_valid || rd_rsp_ready;
  assign accept       = rd_req_valid && rd_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      rd_rsp_fault <= 1'b0;
      mode_q       <= '0;
      wr_fault     <= 1'b0;
    end else begin
      wr_fault <= fault_now;
      if (accept) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= sel_data;
        rd_rsp_fault <= mode.fault;
        mode_q       <= mode;
      end else if (rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
        rd_rsp_fault <= 1'b0;
      end
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && !rd_rsp_ready |=>
      rd_rsp_valid && $stable(rd_rsp_data) && $stable(rd_rsp_fault));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_fault |-> rd_rsp_data == 64'd0);

  p_fast_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && mode_q.fast |-> rd_rsp_data[63:32] == 32'd0);

  p_wfault_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> $past(wr_valid));

  if (CW < 64) begin : g_wchk
    p_norm_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rsp_valid && !mode_q.fixed_grp |-> (rd_rsp_data >> CW) == 64'd0);
  end

endmodule

// File: tb/pmc_access_bench.sv
module pmc_access_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MASK48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_alias = 2'd0;
  logic [7:0]  wr_num = 8'd0;
  logic [63:0] wr_data = 64'd0;
  logic        wr_fault;
  logic        rd_req_valid = 1'b0;
  logic        rd_req_ready;
  logic [31:0] rd_index = 32'd0;
  logic        rd_rsp_valid;
  logic        rd_rsp_ready = 1'b1;
  logic [63:0] rd_rsp_data;
  logic        rd_rsp_fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] gm [4];
  logic [63:0] fm [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_access u_pmc_access (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_alias(wr_alias),
    .wr_num(wr_num), .wr_data(wr_data), .wr_fault(wr_fault),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_index(rd_index), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_fault(rd_rsp_fault)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of a write: returns the expected fault and updates the model
  task automatic model_write(input logic [1:0] a, input logic [7:0] n,
                             input logic [63:0] d, output bit f);
    f = 0;
    case (a)
      2'd0: if (n >= 4) f = 1; else gm[n] = {{32{d[31]}}, d[31:0]} & MASK48;
      2'd1: if (n >= 4 || d[63:48] != 0) f = 1; else gm[n] = d;
      2'd2: if (n >= 3 || d[63:48] != 0) f = 1; else fm[n] = d;
      default: f = 1;
    endcase
  endtask

  function automatic logic [64:0] model_read(input logic [31:0] idx);
    logic [63:0] v;
    bit f;
    f = (idx[29:8] != 0) || (idx[30] ? idx[7:0] >= 3 : idx[7:0] >= 4);
    if (f) return {1'b1, 64'd0};
    v = idx[30] ? fm[idx[7:0]] : gm[idx[7:0]];
    if (idx[31]) v = {32'd0, v[31:0]};
    return {1'b0, v};
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [7:0] n,
                          input logic [63:0] d, input string req);
    bit ef;
    @(negedge clk);
    wr_valid = 1; wr_alias = a; wr_num = n; wr_data = d;
    model_write(a, n, d, ef);
    @(negedge clk);
    wr_valid = 0;
    check(wr_fault == ef, req, 64'(wr_fault), 64'(ef));
  endtask

  task automatic do_read(input logic [31:0] idx, input string req);
    logic [64:0] e;
    e = model_read(idx);
    @(negedge clk);
    rd_rsp_ready = 1; rd_req_valid = 1; rd_index = idx;
    @(negedge clk);
    rd_req_valid = 0;
    check(rd_rsp_valid && rd_rsp_data == e[63:0] && rd_rsp_fault == e[64],
          req, rd_rsp_data, e[63:0]);
  endtask

  function automatic logic [63:0] rand_data();
    case ($urandom % 4)
      0: return {16'd0, 16'($urandom), 32'($urandom)};
      1: return {16'($urandom) | 16'h0100, 16'($urandom), 32'($urandom)};
      2: return {32'($urandom), 1'b1, 31'($urandom)};
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] rand_index();
    logic [31:0] x;
    x = {2'($urandom), 22'd0, 8'($urandom % 5)};
    if ($urandom % 8 == 0) x[29:8] = 22'($urandom) | 22'd1;
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) gm[i] = 0;
    for (int i = 0; i < 3; i++) fm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(!rd_rsp_valid && !wr_fault && rd_req_ready, "R12", 64'(rd_rsp_valid), 64'd0);
    do_read(32'h0000_0003, "R12 counter zero");
    do_read(32'h4000_0002, "R12 fixed zero");

    do_write(2'd0, 8'd0, 64'h0000_0000_8000_0001, "R1 narrow neg");
    do_read(32'h0000_0000, "R1 sign extended");
    do_write(2'd0, 8'd1, 64'hABCD_0000_1234_5678, "R1 narrow upper ignored");
    do_read(32'h0000_0001, "R1 upper ignored");
    do_write(2'd1, 8'd2, 64'h0000_FF01_2345_6789, "R2 wide fits");
    do_read(32'h0000_0002, "R2 wide readback");
    do_write(2'd1, 8'd2, 64'hFFFF_FF01_2345_6789, "R3 wide too big faults");
    do_read(32'h0000_0002, "R3 old value kept");
    do_write(2'd0, 8'd2, 64'h0000_0000_7777_0000, "R4 narrow over wide");
    do_read(32'h0000_0002, "R4 shared storage");
    do_write(2'd1, 8'd2, 64'h0000_8888_0000_1111, "R4 wide over narrow");
    do_read(32'h0000_0002, "R4 shared storage back");
    do_write(2'd2, 8'd2, 64'h0000_1234_ABCD_5678, "R5 fixed write");
    do_read(32'h4000_0002, "R5 fixed group select");
    do_read(32'h0000_0002, "R5 general untouched");
    do_write(2'd2, 8'd1, 64'h0001_0000_0000_0000, "R3 fixed too big");
    do_read(32'h4000_0001, "R3 fixed kept");
    do_read(32'h8000_0000, "R6 fast general");
    do_read(32'hC000_0002, "R6 fast fixed");
    do_read(32'h0000_0040, "R7 general 64");
    do_read(32'h0000_0004, "R7 general 4");
    do_read(32'h4000_0003, "R7 fixed 3");
    do_read(32'h0000_0100, "R8 reserved bit8");
    do_read(32'h2000_0000, "R8 reserved bit29");
    do_write(2'd3, 8'd0, 64'd5, "R11 reserved alias");
    do_write(2'd1, 8'd4, 64'd5, "R11 general number");
    do_write(2'd2, 8'd3, 64'd5, "R11 fixed number");
    do_read(32'h0000_0000, "R11 general 0 kept");
    do_read(32'h0000_0000, "R9 normal width");

    // R10 back-pressure
    @(negedge clk);
    rd_rsp_ready = 0; rd_req_valid = 1; rd_index = 32'h0000_0000;
    @(negedge clk);
    rd_req_valid = 0;
    check(rd_rsp_valid && rd_rsp_data == gm[0], "R10 first", rd_rsp_data, gm[0]);
    check(!rd_req_ready, "R10 req blocked", 64'(rd_req_ready), 64'd0);
    @(negedge clk);
    check(rd_rsp_valid && rd_rsp_data == gm[0], "R10 held", rd_rsp_data, gm[0]);
    rd_rsp_ready = 1;
    @(negedge clk);
    check(!rd_rsp_valid, "R10 drained", 64'(rd_rsp_valid), 64'd0);

    for (int k = 0; k < 600; k++) begin
      if ($urandom % 2 == 0)
        do_write(2'($urandom), 8'($urandom % 5), rand_data(), "R3 random write");
      else
        do_read(rand_index(), "R9 random read");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule